// File: doc/BRIEF.md
# Phase-Step Stall Recovery Controller

This block stands between user logic and the dynamic phase-adjust port of a clock synthesiser. A requester hands it one phase-step command at a time (a direction bit and a counter select). The controller holds those values steady toward the synthesiser, raises the step strobe for a programmable number of cycles, and then follows the done handshake. The handshake is expected to fall while the shift is in progress and to rise again when the shift is complete.

The done line can stick low, and when it does the shift has not actually happened. The controller bounds each wait with a timeout. When the timeout expires it strobes the step line again on its own. This makes up the missed shift and frees the handshake, and it is not treated as a new request. If the number of such retries exceeds a limit, the controller gives up. It asks for a synthesiser reset with a single-cycle pulse and raises an error flag, which stays up until the next request is accepted. While an operation is in flight the controller reports itself not ready, and any request made during that time is dropped rather than queued.

Top module: `phase_step_recovery`

## Requirements
- R1: After reset, req_ready is 1, and pll_phasestep, done_pulse, err_flag and pll_reset_req are all 0.
- R2: When req_valid is 1 while req_ready is 1, the request is taken, and pll_phasestep goes high for exactly STEP_CYC consecutive cycles.
- R3: req_ready is 0 from the cycle after a request is taken until the operation ends. A req_valid seen while req_ready is 0 is dropped: it starts no operation, either at that time or later.
- R4: pll_updn and pll_cntsel carry the req_updn and req_cntsel values of the accepted request, and they stay unchanged for the whole operation, retries included.
- R5: Once the strobe ends, pll_phasedone going low and then high within TIMEOUT cycles ends the operation. done_pulse is then high for one cycle and req_ready returns to 1.
- R6: If the handshake does not complete within TIMEOUT cycles, the step strobe is reissued with the same held values. A retry raises neither req_ready nor done_pulse, so an operation with k stalls and k <= MAX_RETRY shows k+1 strobes and one done_pulse.
- R7: When another stall follows MAX_RETRY retries, pll_reset_req is high for exactly one cycle and no done_pulse is given. err_flag goes to 1 in the next cycle. A failed operation shows MAX_RETRY+1 strobes.
- R8: err_flag stays 1 through idle cycles. It clears in the cycle after the next request is taken, and the retry count starts from zero for every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Phase-step request |
| req_updn | input | 1 | Requested shift direction |
| req_cntsel | input | CSEL_W | Requested counter select |
| req_ready | output | 1 | High when idle and able to take a request |
| done_pulse | output | 1 | One-cycle pulse when a shift completes |
| err_flag | output | 1 | Retries exhausted; held until next accepted request |
| pll_phasedone | input | 1 | Handshake from the synthesiser (low while shifting) |
| pll_phasestep | output | 1 | Step strobe to the synthesiser |
| pll_updn | output | 1 | Held direction toward the synthesiser |
| pll_cntsel | output | CSEL_W | Held counter select toward the synthesiser |
| pll_reset_req | output | 1 | One-cycle request to reset the synthesiser |

## Verification
The bench builds the block with STEP_CYC=2, TIMEOUT=8, MAX_RETRY=2 and a 3-bit counter select. With these values it can sweep every stall count from zero up to one past the retry limit, against both directions and all eight select values. Both a successful recovery at every retry depth and the failure path with its reset request come within reach in a few dozen cycles each. A behavioural stub of the synthesiser stalls a chosen number of attempts in a row and records the held values when each shift completes.

// File: rtl/psr_pkg.sv
package psr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_WAIT_LOW,
        ST_WAIT_HIGH,
        ST_RETRY,
        ST_FAIL
    } psr_state_e;
endpackage

// File: rtl/psr_timer.sv
module psr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (dec)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R6: the controller never counts down past zero
    a_r6_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));
endmodule

// File: rtl/phase_step_recovery.sv
module phase_step_recovery #(
    parameter int CSEL_W    = 3,
    parameter int STEP_CYC  = 2,
    parameter int TIMEOUT   = 8,
    parameter int MAX_RETRY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_updn,
    input  logic [CSEL_W-1:0] req_cntsel,
    output logic              req_ready,
    output logic              done_pulse,
    output logic              err_flag,
    input  logic              pll_phasedone,
    output logic              pll_phasestep,
    output logic              pll_updn,
    output logic [CSEL_W-1:0] pll_cntsel,
    output logic              pll_reset_req
);
    import psr_pkg::*;

    localparam int STEP_W = $clog2(STEP_CYC + 1);
    localparam int TMO_W  = $clog2(TIMEOUT + 1);
    localparam int RTY_W  = $clog2(MAX_RETRY + 1);

    typedef struct packed {
        psr_state_e        st;
        logic              updn;
        logic [CSEL_W-1:0] csel;
        logic [RTY_W-1:0]  retry;
        logic              err;
        logic              done;
    } ctl_t;

    ctl_t r_d, r_q;
    logic step_load, step_dec, step_zero;
    logic tmo_load, tmo_dec, tmo_zero;

    psr_timer #(.W(STEP_W)) u_step_tmr (
        .clk(clk), .rst_n(rst_n), .load(step_load),
        .load_val(STEP_W'(STEP_CYC - 1)), .dec(step_dec), .zero(step_zero)
    );

    psr_timer #(.W(TMO_W)) u_wait_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmo_load),
        .load_val(TMO_W'(TIMEOUT - 1)), .dec(tmo_dec), .zero(tmo_zero)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        step_load = 1'b0;
        step_dec  = 1'b0;
        tmo_load  = 1'b0;
        tmo_dec   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_STEP;
                    r_d.updn  = req_updn;
                    r_d.csel  = req_cntsel;
                    r_d.retry = '0;
                    r_d.err   = 1'b0;
                    step_load = 1'b1;
                end
            end
            ST_STEP: begin
                if (step_zero) begin
                    r_d.st   = ST_WAIT_LOW;
                    tmo_load = 1'b1;
                end else begin
                    step_dec = 1'b1;
                end
            end
            ST_WAIT_LOW: begin
                if (!pll_phasedone) begin
                    r_d.st  = ST_WAIT_HIGH;
                    tmo_dec = !tmo_zero;
                end else if (tmo_zero) begin
                    r_d.st = ST_RETRY;
                end else begin
                    tmo_dec = 1'b1;
                end
            end
            ST_WAIT_HIGH: begin
                if (pll_phasedone) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else if (tmo_zero) begin
                    r_d.st = ST_RETRY;
                end else begin
                    tmo_dec = 1'b1;
                end
            end
            ST_RETRY: begin
                if (r_q.retry == RTY_W'(MAX_RETRY)) begin
                    r_d.st = ST_FAIL;
                end else begin
                    r_d.retry = r_q.retry + 1'b1;
                    r_d.st    = ST_STEP;
                    step_load = 1'b1;
                end
            end
            ST_FAIL: begin
                r_d.err = 1'b1;
                r_d.st  = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, updn: 1'b0, csel: '0, retry: '0, err: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign pll_phasestep = (r_q.st == ST_STEP);
    assign pll_reset_req = (r_q.st == ST_FAIL);
    assign pll_updn      = r_q.updn;
    assign pll_cntsel    = r_q.csel;
    assign done_pulse    = r_q.done;
    assign err_flag      = r_q.err;

    // R3: the strobe is only ever driven while busy
    a_r3_step_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pll_phasestep |-> !req_ready);
    // R4: held values do not move between two busy cycles
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> ($stable(pll_updn) && $stable(pll_cntsel)));
    // R5/R7: completion and reset request never coincide
    a_r5_done_or_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_pulse, pll_reset_req}));
    // R5: completion pulse lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
    // R7: reset request is a single-cycle pulse followed by the error flag
    a_r7_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
        pll_reset_req |=> (!pll_reset_req && err_flag));
    // R6: retry counter never exceeds its limit
    a_r6_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.retry <= RTY_W'(MAX_RETRY));
    // R8: the error flag can only clear when a request is taken
    a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(req_ready && req_valid)) |=> err_flag);
endmodule

// File: tb/phase_step_recovery_tb.sv
module phase_step_recovery_tb;
    localparam int CSEL_W    = 3;
    localparam int STEP_CYC  = 2;
    localparam int TIMEOUT   = 8;
    localparam int MAX_RETRY = 2;
    localparam int DUR       = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_updn = 1'b0;
    logic [CSEL_W-1:0] req_cntsel = '0;
    logic req_ready, done_pulse, err_flag;
    logic pll_phasedone = 1'b1;
    logic pll_phasestep, pll_updn, pll_reset_req;
    logic [CSEL_W-1:0] pll_cntsel;

    always #2.5 clk = ~clk;

    phase_step_recovery #(.CSEL_W(CSEL_W), .STEP_CYC(STEP_CYC), .TIMEOUT(TIMEOUT),
                          .MAX_RETRY(MAX_RETRY)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_updn(req_updn),
        .req_cntsel(req_cntsel), .req_ready(req_ready), .done_pulse(done_pulse),
        .err_flag(err_flag), .pll_phasedone(pll_phasedone), .pll_phasestep(pll_phasestep),
        .pll_updn(pll_updn), .pll_cntsel(pll_cntsel), .pll_reset_req(pll_reset_req)
    );

    int total = 0;
    int fails = 0;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural synthesiser stub and monitor, sampled on the falling edge
    int stall_left = 0;
    bit stuck = 0;
    int dcnt = 0;
    logic ps_prev = 1'b0;
    int n_rise = 0, n_high = 0, n_done = 0, n_rst = 0, n_shift = 0;
    int busy_cyc = 0, max_run = 0, run = 0, bad_width = 0;
    logic shift_updn = 1'b0;
    logic [CSEL_W-1:0] shift_csel = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pll_phasestep && !ps_prev) begin
                n_rise++;
                pll_phasedone <= 1'b0;
                if (stall_left > 0) begin
                    stall_left--;
                    stuck = 1;
                end else begin
                    stuck = 0;
                    dcnt  = DUR;
                end
            end else if (!stuck && dcnt > 0) begin
                dcnt--;
                if (dcnt == 0) begin
                    pll_phasedone <= 1'b1;
                    n_shift++;
                    shift_updn = pll_updn;
                    shift_csel = pll_cntsel;
                end
            end
            if (pll_phasestep) begin
                n_high++;
                run++;
            end else begin
                if (ps_prev && run != STEP_CYC) bad_width++;
                run = 0;
            end
            if (done_pulse) n_done++;
            if (pll_reset_req) n_rst++;
            ps_prev = pll_phasestep;
        end
    end

    task automatic run_op(input int stalls, input logic ud, input logic [CSEL_W-1:0] cs,
                          input bit poke_busy, input bit err_before);
        int wait_n;
        bit fail_exp;
        int steps_exp;
        fail_exp  = (stalls > MAX_RETRY);
        steps_exp = fail_exp ? MAX_RETRY + 1 : stalls + 1;
        stall_left = stalls;
        n_rise = 0; n_high = 0; n_done = 0; n_rst = 0; n_shift = 0; bad_width = 0;
        @(negedge clk);
        chk("R8 err before accept", int'(err_flag), int'(err_before));
        req_valid  = 1'b1;
        req_updn   = ud;
        req_cntsel = cs;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 busy after accept", int'(req_ready), 0);
        chk("R8 err cleared on accept", int'(err_flag), 0);
        if (poke_busy) begin
            req_valid  = 1'b1;
            req_updn   = ~ud;
            req_cntsel = ~cs;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait_n = 0;
        while (n_done == 0 && n_rst == 0 && wait_n < 400) begin
            @(negedge clk);
            wait_n++;
        end
        repeat (6) @(negedge clk);
        chk("R2 strobe width", bad_width, 0);
        chk("R6/R7 strobe count", n_rise, steps_exp);
        chk("R2 strobe cycles", n_high, steps_exp * STEP_CYC);
        chk("R3 ready after op", int'(req_ready), 1);
        if (fail_exp) begin
            chk("R7 reset pulses", n_rst, 1);
            chk("R7 no done", n_done, 0);
            chk("R7 err set", int'(err_flag), 1);
        end else begin
            chk("R5 done pulses", n_done, 1);
            chk("R6 no reset", n_rst, 0);
            chk("R5 no err", int'(err_flag), 0);
            chk("R4 shift updn", int'(shift_updn), int'(ud));
            chk("R4 shift csel", int'(shift_csel), int'(cs));
        end
        chk("R4 held updn", int'(pll_updn), int'(ud));
        chk("R4 held csel", int'(pll_cntsel), int'(cs));
    endtask

    initial begin
        bit err_now;
        repeat (3) @(negedge clk);
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 step", int'(pll_phasestep), 0);
        chk("R1 done", int'(done_pulse), 0);
        chk("R1 err", int'(err_flag), 0);
        chk("R1 reset req", int'(pll_reset_req), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        err_now = 0;
        for (int s = 0; s <= MAX_RETRY + 1; s++) begin
            for (int u = 0; u < 2; u++) begin
                for (int c = 0; c < (1 << CSEL_W); c++) begin
                    run_op(s, u[0], c[CSEL_W-1:0], (c == 5), err_now);
                    err_now = (s > MAX_RETRY);
                    if (err_now) begin
                        repeat (4) @(negedge clk);
                        chk("R8 err held idle", int'(err_flag), 1);
                    end
                end
            end
        end
        // R8: retry count restarts after a failure
        run_op(MAX_RETRY, 1'b1, 3'd2, 1'b0, err_now);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end
endmodule